// File: doc/BRIEF.md
# Load/Store Byte Lane Alignment Unit

This unit is placed between the memory stage of a processor pipeline and a data memory that is 32 bits wide and byte-enabled. It takes a load or store request and adds the base register to a 16-bit signed byte offset to form the effective address. It then checks that the address is naturally aligned for the access size. For a store, it produces the lane byte enables and the lane-replicated write data. For a load, it issues a read and then returns the addressed byte, half-word or word from the memory word. The result is sign- or zero-extended to 32 bits.

The `BIG_ENDIAN` parameter sets how byte addresses map onto the lanes of a word. When it is 0, byte address 0 is in the least significant lane. When it is 1, byte address 0 is in the most significant lane. The memory is assumed to read synchronously, so the read word comes back on the cycle after the read strobe. The unit registers the lane, size and extension mode of each accepted load and presents the response on that next cycle. A misaligned access is not split. It raises an error flag and no memory operation takes place.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_offset` sign-extended to the address width, in the same cycle as the request.
- R2: `addr_err` is high during a valid request when the size is word (code 2) and the two low address bits are not both zero, or the size is half-word (code 1) and address bit 0 is one, or the size is the reserved code 3. A byte access (code 0) never raises it.
- R3: During a misaligned request, `mem_we` and `mem_re` stay low and `mem_be` is 0, and no load response follows on the next cycle.
- R4: In a store, lane k is `mem_wdata[8k+7:8k]` and `mem_be[k]`. With `BIG_ENDIAN`=0, the byte at address offset a (the two low address bits) uses lane a. With `BIG_ENDIAN`=1 it uses lane 3-a. A half-word enables the lanes of its two bytes, and a word enables all four lanes.
- R5: Store write data repeats the low byte in all four lanes for a byte store and the low half-word in both halves for a half-word store, and passes the word through unchanged for a word store.
- R6: `rsp_valid` is high in exactly the cycle after an aligned load request (`req_valid`=1, `req_write`=0) is accepted, and is low at all other times.
- R7: `rsp_data` holds the loaded byte or half-word, sign-extended when `req_unsigned` was 0 and zero-extended when it was 1. A loaded word is returned unchanged.
- R8: A load picks its bytes from `mem_rdata` using the same lane mapping as R4. A big-endian half-word takes its most significant byte from the lower address, and a little-endian half-word takes it from the higher address.
- R9: While reset is held and after it is released, `rsp_valid` is low until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_unsigned | input | 1 | Load zero-extends instead of sign-extending |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset |
| req_wdata | input | 32 | Store data, right-justified |
| addr_err | output | 1 | Misaligned or reserved-size request |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 4 | Lane byte enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_re` |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |

## Verification
The address, the error flag, the strobes, the byte enables and the write data are all combinational from the request, so they are due in the request cycle itself. The bench drives each request just after a falling edge and samples these outputs one time unit later, before the next rising edge. Load results are due one rising edge after the request. The bench therefore presents the read word at the next falling edge and checks `rsp_valid` and `rsp_data` there. For rejected loads it checks that `rsp_valid` stays low in that same slot. A little-endian and a big-endian instance receive the same stimulus and are checked against separately computed lane models.

// File: rtl/lsu_align_pkg.sv
// Shared types and constants for the load/store alignment unit.
// Assumes a memory word of four 8-bit lanes.
package lsu_align_pkg;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned WORD_LANES = 4;
    localparam int unsigned WORD_W     = LANE_W * WORD_LANES;
    localparam int unsigned LANE_IDX_W = $clog2(WORD_LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
// Effective address adder and natural-alignment checker.
// Assumes the offset is a two's-complement byte count narrower than the address.
module lsu_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [OFF_W-1:0]        offset,
    input  lsu_align_pkg::acc_size_e size,
    output logic [ADDR_W-1:0]       eff_addr,
    output logic                    misaligned
);
    import lsu_align_pkg::*;

    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    // Sum the base and the sign-extended offset.
    always_comb begin
        eff_addr = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    end

    // Flag addresses that are not a multiple of the access size.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = eff_addr[0];
            SZ_WORD: misaligned = |eff_addr[1:0];
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_lane_map.sv
// Maps the byte offset within a word to the lowest memory lane used by the access.
// Assumes the access is aligned; BIG_ENDIAN selects the lane numbering.
module lsu_lane_map #(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [lsu_align_pkg::LANE_IDX_W-1:0] byte_off,
    input  lsu_align_pkg::acc_size_e             size,
    output logic [lsu_align_pkg::LANE_IDX_W-1:0] low_lane
);
    import lsu_align_pkg::*;

    localparam logic [LANE_IDX_W-1:0] TOP_LANE  = LANE_IDX_W'(WORD_LANES - 1);
    localparam logic [LANE_IDX_W-1:0] HALF_TOP  = LANE_IDX_W'(WORD_LANES - 2);

    generate
        if (BIG_ENDIAN) begin : g_big
            // Lower addresses occupy higher lanes.
            always_comb begin
                unique case (size)
                    SZ_BYTE: low_lane = TOP_LANE - byte_off;
                    SZ_HALF: low_lane = HALF_TOP - byte_off;
                    default: low_lane = '0;
                endcase
            end
        end else begin : g_little
            // Lane index equals the byte offset.
            always_comb begin
                unique case (size)
                    SZ_BYTE, SZ_HALF: low_lane = byte_off;
                    default:          low_lane = '0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/lsu_store_lane.sv
// Builds lane byte enables and lane-replicated write data for a store.
// Assumes low_lane comes from lsu_lane_map for an aligned access.
module lsu_store_lane (
    input  lsu_align_pkg::acc_size_e              size,
    input  logic [lsu_align_pkg::LANE_IDX_W-1:0]  low_lane,
    input  logic [lsu_align_pkg::WORD_W-1:0]      wdata_in,
    output logic [lsu_align_pkg::WORD_LANES-1:0]  lane_be,
    output logic [lsu_align_pkg::WORD_W-1:0]      wdata_out
);
    import lsu_align_pkg::*;

    // Select which lanes the access touches.
    always_comb begin
        unique case (size)
            SZ_BYTE: lane_be = WORD_LANES'(1) << low_lane;
            SZ_HALF: lane_be = WORD_LANES'(3) << low_lane;
            default: lane_be = '1;
        endcase
    end

    // Place source bytes in every lane so any enabled lane sees its byte.
    for (genvar k = 0; k < WORD_LANES; k++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata_out[k*LANE_W +: LANE_W] = wdata_in[0 +: LANE_W];
                SZ_HALF: wdata_out[k*LANE_W +: LANE_W] = wdata_in[(k % 2)*LANE_W +: LANE_W];
                default: wdata_out[k*LANE_W +: LANE_W] = wdata_in[k*LANE_W +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Selects the addressed bytes of a read word and extends them to a full word.
// Assumes low_lane and size were captured with the originating request.
module lsu_load_extract (
    input  logic [lsu_align_pkg::WORD_W-1:0]     rdata,
    input  logic [lsu_align_pkg::LANE_IDX_W-1:0] low_lane,
    input  lsu_align_pkg::acc_size_e             size,
    input  logic                                 zero_ext,
    output logic [lsu_align_pkg::WORD_W-1:0]     result
);
    import lsu_align_pkg::*;

    localparam int unsigned HALF_W = 2 * LANE_W;

    logic [WORD_W-1:0] shifted;
    logic [LANE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;

    // Move the lowest used lane down to bit 0.
    always_comb begin
        shifted  = rdata >> {low_lane, 3'b000};
        sel_byte = shifted[LANE_W-1:0];
        sel_half = shifted[HALF_W-1:0];
    end

    // Extend the selected field according to size and signedness.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(WORD_W-LANE_W){sel_byte[LANE_W-1] & ~zero_ext}}, sel_byte};
            SZ_HALF: result = {{(WORD_W-HALF_W){sel_half[HALF_W-1] & ~zero_ext}}, sel_half};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
// Top of the load/store alignment unit: address generation, alignment check,
// store lane steering and a one-cycle registered load response path.
// Assumes a synchronous-read memory returning data the cycle after mem_re.
module lsu_align_unit #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned OFF_W      = 16,
    parameter bit          BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [31:0]       req_wdata,
    output logic              addr_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);
    import lsu_align_pkg::*;

    acc_size_e             size_q;
    acc_size_e             req_sz;
    logic                  misaligned;
    logic [LANE_IDX_W-1:0] req_lane;
    logic [WORD_LANES-1:0] lane_be;
    logic [WORD_W-1:0]     lane_wdata;
    logic [WORD_W-1:0]     ext_data;
    logic                  ld_pend_q;
    logic [LANE_IDX_W-1:0] ld_lane_q;
    logic                  ld_zext_q;
    logic                  accept_ld;

    assign req_sz = acc_size_e'(req_size);

    lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr_gen (
        .base       (req_base),
        .offset     (req_offset),
        .size       (req_sz),
        .eff_addr   (mem_addr),
        .misaligned (misaligned)
    );

    lsu_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) i_lane_map (
        .byte_off (mem_addr[LANE_IDX_W-1:0]),
        .size     (req_sz),
        .low_lane (req_lane)
    );

    lsu_store_lane i_store_lane (
        .size      (req_sz),
        .low_lane  (req_lane),
        .wdata_in  (req_wdata),
        .lane_be   (lane_be),
        .wdata_out (lane_wdata)
    );

    lsu_load_extract i_load_extract (
        .rdata    (mem_rdata),
        .low_lane (ld_lane_q),
        .size     (size_q),
        .zero_ext (ld_zext_q),
        .result   (ext_data)
    );

    // Gate memory strobes and enables with the alignment result.
    always_comb begin
        addr_err  = req_valid & misaligned;
        mem_we    = req_valid & req_write & ~misaligned;
        mem_re    = req_valid & ~req_write & ~misaligned;
        mem_be    = (req_valid & ~misaligned) ? lane_be : '0;
        mem_wdata = lane_wdata;
        accept_ld = mem_re;
    end

    // Capture the decode of an accepted load for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q <= 1'b0;
            ld_lane_q <= '0;
            ld_zext_q <= 1'b0;
            size_q    <= SZ_WORD;
        end else begin
            ld_pend_q <= accept_ld;
            if (accept_ld) begin
                ld_lane_q <= req_lane;
                ld_zext_q <= req_unsigned;
                size_q    <= req_sz;
            end
        end
    end

    // Present the extended result only while a response is due.
    always_comb begin
        rsp_valid = ld_pend_q;
        rsp_data  = ld_pend_q ? ext_data : '0;
    end
endmodule

// File: rtl/lsu_align_unit_chk.sv
// Property checker for lsu_align_unit, attached by bind.
module lsu_align_unit_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              addr_err,
    input logic              mem_we,
    input logic              mem_re,
    input logic [3:0]        mem_be,
    input logic              rsp_valid
);
    // R2: a word request off a four-byte boundary is flagged
    assert_word_misalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && mem_addr[1:0] != 2'b00) |-> addr_err);

    // R2: byte requests are never flagged
    assert_byte_never_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |-> !addr_err);

    // R3: a flagged request touches no memory
    assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!mem_we && !mem_re && mem_be == 4'b0000));

    // R4: a byte store enables exactly one lane
    assert_byte_store_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && req_size == 2'd0) |-> $countones(mem_be) == 1);

    // R6: an accepted load is answered on the next cycle
    assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rsp_valid);

    // R6: no response without a load accepted one cycle before
    assert_rsp_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(!rst_n)) |-> $past(req_valid && !req_write && !addr_err));
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .mem_addr  (mem_addr),
    .addr_err  (addr_err),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_be    (mem_be),
    .rsp_valid (rsp_valid)
);

// File: tb/test_lsu_align_unit.sv
// Directed bench: a little-endian and a big-endian instance share stimulus.
module test_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;

    logic        err_l, we_l, re_l, rv_l;
    logic [31:0] addr_l, wd_l, rd_l;
    logic [3:0]  be_l;
    logic        err_b, we_b, re_b, rv_b;
    logic [31:0] addr_b, wd_b, rd_b;
    logic [3:0]  be_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_align_unit #(.BIG_ENDIAN(1'b0)) i_lsu_align_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_offset(req_offset), .req_wdata(req_wdata), .addr_err(err_l),
        .mem_addr(addr_l), .mem_we(we_l), .mem_re(re_l), .mem_be(be_l),
        .mem_wdata(wd_l), .mem_rdata(mem_rdata), .rsp_valid(rv_l), .rsp_data(rd_l)
    );

    lsu_align_unit #(.BIG_ENDIAN(1'b1)) i_lsu_align_unit_be (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_offset(req_offset), .req_wdata(req_wdata), .addr_err(err_b),
        .mem_addr(addr_b), .mem_we(we_b), .mem_re(re_b), .mem_be(be_b),
        .mem_wdata(wd_b), .mem_rdata(mem_rdata), .rsp_valid(rv_b), .rsp_data(rd_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Byte at address offset i of a word, for either lane order.
    function automatic logic [7:0] mem_byte(input bit big, input logic [31:0] w, input int i);
        return big ? w[8*(3-i) +: 8] : w[8*i +: 8];
    endfunction

    function automatic logic [3:0] model_be(input bit big, input int sz, input int a);
        if (sz == 0) return big ? 4'(1 << (3 - a)) : 4'(1 << a);
        if (sz == 1) return ((a == 0) ^ big) ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] model_load(input bit big, input int sz, input bit uns,
                                               input int a, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        if (sz == 0) begin
            b = mem_byte(big, w, a);
            return uns ? {24'h0, b} : {{24{b[7]}}, b};
        end
        if (sz == 1) begin
            h = big ? {mem_byte(big, w, a), mem_byte(big, w, a + 1)}
                    : {mem_byte(big, w, a + 1), mem_byte(big, w, a)};
            return uns ? {16'h0, h} : {{16{h[15]}}, h};
        end
        return big ? {mem_byte(big,w,0), mem_byte(big,w,1), mem_byte(big,w,2), mem_byte(big,w,3)}
                   : {mem_byte(big,w,3), mem_byte(big,w,2), mem_byte(big,w,1), mem_byte(big,w,0)};
    endfunction

    task automatic drive(input bit wr, input int sz, input bit uns,
                         input logic [31:0] base, input logic [15:0] off, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_unsigned = uns;
        req_base = base; req_offset = off; req_wdata = wd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R9 rsp_valid in reset le", 32'(rv_l), 32'd0);
        check("R9 rsp_valid in reset be", 32'(rv_b), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R9 rsp_valid after reset", 32'(rv_l | rv_b), 32'd0);
        check("R9 no write when idle", 32'(we_l | we_b), 32'd0);
    endtask

    task automatic t_addr();
        drive(1'b0, 0, 1'b0, 32'h0000_1000, 16'hFFFC, '0);
        check("R1 negative offset", addr_l, 32'h0000_0FFC);
        drive(1'b0, 0, 1'b0, 32'h0000_1000, 16'h0013, '0);
        check("R1 positive offset", addr_l, 32'h0000_1013);
        drive(1'b0, 0, 1'b0, 32'h0000_0004, 16'h8000, '0);
        check("R1 offset wraps", addr_b, 32'hFFFF_8004);
        idle(); idle();
    endtask

    // Every size against every address offset, as loads.
    task automatic t_align();
        for (int sz = 0; sz < 4; sz++) begin
            for (int a = 0; a < 4; a++) begin
                bit bad;
                bad = (sz == 3) || (sz == 2 && a != 0) || (sz == 1 && a[0]);
                drive(1'b0, sz, 1'b0, 32'h0000_2000, 16'(a), '0);
                check($sformatf("R2 err size=%0d a=%0d", sz, a), 32'(err_l), 32'(bad));
                check($sformatf("R3 read strobe size=%0d a=%0d", sz, a), 32'(re_b), 32'(!bad));
                if (bad) check("R3 enables zero on error", 32'(be_l | be_b), 32'd0);
                idle();
                check($sformatf("R6 R3 response size=%0d a=%0d", sz, a), 32'(rv_l), 32'(!bad));
            end
        end
        drive(1'b1, 2, 1'b0, 32'h0000_2001, 16'h0000, 32'h1234_5678);
        check("R3 misaligned store no write", 32'(we_l | we_b), 32'd0);
        idle();
        check("R3 misaligned store no response", 32'(rv_l), 32'd0);
    endtask

    task automatic t_store();
        logic [31:0] wd;
        wd = 32'hA1B2_C3D4;
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < 4; a += (sz == 0) ? 1 : (sz == 1 ? 2 : 4)) begin
                logic [31:0] exp_wd;
                exp_wd = (sz == 0) ? {4{wd[7:0]}} : (sz == 1) ? {2{wd[15:0]}} : wd;
                drive(1'b1, sz, 1'b0, 32'h0000_3000, 16'(a), wd);
                check($sformatf("R4 be le size=%0d a=%0d", sz, a), 32'(be_l), 32'(model_be(1'b0, sz, a)));
                check($sformatf("R4 be be size=%0d a=%0d", sz, a), 32'(be_b), 32'(model_be(1'b1, sz, a)));
                check($sformatf("R5 wdata size=%0d", sz), wd_l, exp_wd);
                check($sformatf("R5 wdata be size=%0d", sz), wd_b, exp_wd);
                check("R4 write strobe", 32'(we_l & we_b), 32'd1);
            end
        end
        idle();
    endtask

    task automatic t_load(input logic [31:0] word);
        for (int sz = 0; sz < 3; sz++) begin
            for (int uns = 0; uns < 2; uns++) begin
                for (int a = 0; a < 4; a += (sz == 0) ? 1 : (sz == 1 ? 2 : 4)) begin
                    drive(1'b0, sz, uns[0], 32'h0000_4000, 16'(a), '0);
                    @(negedge clk);
                    req_valid = 1'b0;
                    mem_rdata = word;
                    #1;
                    check("R6 response valid", 32'(rv_l & rv_b), 32'd1);
                    check($sformatf("R7 R8 le size=%0d u=%0d a=%0d", sz, uns, a),
                          rd_l, model_load(1'b0, sz, uns[0], a, word));
                    check($sformatf("R7 R8 be size=%0d u=%0d a=%0d", sz, uns, a),
                          rd_b, model_load(1'b1, sz, uns[0], a, word));
                    idle();
                    check("R6 single-cycle response", 32'(rv_l | rv_b), 32'd0);
                end
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_addr();
        t_align();
        t_store();
        t_load(32'h80FF_7F01);
        t_load(32'h0123_C5E6);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule